// File: doc/BRIEF.md
# Byte Memory Host Access Port with Auto-Increment

This block owns a small byte-wide memory that a microcontroller executes from and that a host loads and inspects through a narrow register window. The host first raises an enable bit in a control register, then polls a power field until the memory reports itself awake. After that it loads a start offset into a write or read pointer and streams bytes through a single data register. Each pointer moves forward by one per data access only when its own auto-increment bit is set, so the same window serves both bulk loading and repeated polling of a single location.

While the host holds the enable bit, the microcontroller's fetch port is fenced off: it returns zero and raises a stall. Clearing the enable bit, along with both increment bits, hands the memory back to the microcontroller and lets it drop into its sleep state. The wake latency is a parameter. The pointers are 8 bits wide and wrap around.

Top module: `iram_host_port`

## Requirements
- R1: After reset, the control register reads 0, both pointers read 0x00, the power field reads 2 (asleep) and `uc_stall` is low.
- R2: Once the enable bit is set, the power field reads 1 (waking) for exactly WAKE_CYCLES cycles and then reads 0 (awake) while enable stays set.
- R3: Clearing the enable bit makes the power field read 2 from the next cycle on. Setting it again restarts the full wake sequence of R2.
- R4: Data accesses take effect only while the power field reads 0. At any other time a write to the write-data register stores nothing and moves no pointer, and a read of the read-data register returns 0 and moves no pointer.
- R5: A write to either address register while the enable bit is clear is ignored.
- R6: Writing the write-address register loads the write pointer. Each write to the write-data register stores one byte at that pointer, which then advances by one only if write auto-increment (control bit 1) is set.
- R7: Writing the read-address register loads the read pointer. Each read of the read-data register returns the byte at that pointer, which then advances by one only if read auto-increment (control bit 2) is set. Consecutive reads therefore return consecutive bytes in address order, for example a version byte, a two-byte year and a month/day stored from offset 0xF1.
- R8: Both pointers wrap from 0xFF to 0x00.
- R9: With enable clear, `uc_data` shows the byte at `uc_addr` in the same cycle and `uc_stall` is low. With enable set, `uc_data` is 0 and `uc_stall` is high.
- R10: Register offsets on `reg_addr` are as follows. 0 is control (bit 0 enable, bit 1 write increment, bit 2 read increment; readable). 1 is the write address, which reads back the write pointer. 2 is write data. 3 is the read address, which reads back the read pointer. 4 is read data. 5 is the power field (read only). `reg_rdata` is combinational on the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 3 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for `reg_addr` |
| uc_addr | input | 8 | Microcontroller fetch address |
| uc_data | output | 8 | Microcontroller fetch data |
| uc_stall | output | 1 | Fetch fenced off by host access |

## Verification
A host store into the memory and a microcontroller fetch of the very same address can land in one cycle. The bench provokes this by pointing `uc_addr` at the write pointer on the cycle the host writes the data register. The fetch must see 0 with the stall raised, not the old byte and not the new one. After the host releases the enable bit, the same fetch must return the newly stored byte. A second overlap, a data access during the wake window right after re-enable, is judged through the pointer readback and a later read of the target byte.

// File: rtl/iram_pkg.sv
package iram_pkg;

    typedef enum logic [1:0] {
        PWR_AWAKE  = 2'd0,
        PWR_WAKING = 2'd1,
        PWR_ASLEEP = 2'd2
    } pwr_e;

    typedef struct packed {
        logic rd_inc;
        logic wr_inc;
        logic host_en;
    } ctrl_t;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_WADDR = 3'd1;
    localparam logic [2:0] OFS_WDATA = 3'd2;
    localparam logic [2:0] OFS_RADDR = 3'd3;
    localparam logic [2:0] OFS_RDATA = 3'd4;
    localparam logic [2:0] OFS_PWR   = 3'd5;

endpackage

// File: rtl/iram_power_ctrl.sv
module iram_power_ctrl
    import iram_pkg::*;
#(
    parameter int WAKE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_en,
    output pwr_e state,
    output logic access_ok
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(WAKE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pwr_st_t;

    pwr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!host_en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_DONE) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (!host_en)                state = PWR_ASLEEP;
        else if (st_q.cnt == CNT_DONE) state = PWR_AWAKE;
        else                         state = PWR_WAKING;
    end

    assign access_ok = (state == PWR_AWAKE);

    // R2
    wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_en) |-> state == PWR_WAKING);

    // R3
    sleep_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_en) |-> state == PWR_ASLEEP);

    // R2
    awake_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> $past(host_en));

endmodule

// File: rtl/iram_ptr.sv
module iram_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          inc_en,
    output logic [AW-1:0] ptr
);
    typedef struct packed {
        logic [AW-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ptr = load_val;
        end else if (step && inc_en) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;

    // R8
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inc_en && !load) |=> ptr == AW'($past(ptr) + 1'b1));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(step && inc_en)) |=> $stable(ptr));

endmodule

// File: rtl/iram_store.sv
module iram_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/iram_host_port.sv
module iram_host_port
    import iram_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int WAKE_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [AW-1:0] uc_addr,
    output logic [DW-1:0] uc_data,
    output logic          uc_stall
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t ctrl;
    } top_st_t;

    top_st_t st_d, st_q;

    pwr_e          pwr_state;
    logic          access_ok;
    logic          host_en;
    logic          wload, wstep, rload, rstep;
    logic [AW-1:0] wptr, rptr;
    logic [DW-1:0] host_byte, fetch_byte;

    assign host_en = st_q.ctrl.host_en;

    always_comb begin
        st_d = st_q;
        if (reg_wr && reg_addr == OFS_CTRL) begin
            st_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // strobes for the two pointers
    assign wload = reg_wr && reg_addr == OFS_WADDR && host_en;
    assign wstep = reg_wr && reg_addr == OFS_WDATA && access_ok;
    assign rload = reg_wr && reg_addr == OFS_RADDR && host_en;
    assign rstep = reg_rd && reg_addr == OFS_RDATA && access_ok;

    iram_power_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_en   (host_en),
        .state     (pwr_state),
        .access_ok (access_ok)
    );

    iram_ptr #(.AW(AW)) u_wptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wload),
        .load_val (reg_wdata[AW-1:0]),
        .step     (wstep),
        .inc_en   (st_q.ctrl.wr_inc),
        .ptr      (wptr)
    );

    iram_ptr #(.AW(AW)) u_rptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rload),
        .load_val (reg_wdata[AW-1:0]),
        .step     (rstep),
        .inc_en   (st_q.ctrl.rd_inc),
        .ptr      (rptr)
    );

    iram_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .we      (wstep),
        .waddr   (wptr),
        .wdata   (reg_wdata),
        .raddr_a (rptr),
        .rdata_a (host_byte),
        .raddr_b (uc_addr),
        .rdata_b (fetch_byte)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL:  reg_rdata = DW'(st_q.ctrl);
            OFS_WADDR: reg_rdata = DW'(wptr);
            OFS_RADDR: reg_rdata = DW'(rptr);
            OFS_RDATA: reg_rdata = access_ok ? host_byte : '0;
            OFS_PWR:   reg_rdata = DW'(pwr_state);
            default:   reg_rdata = '0;
        endcase
    end

    assign uc_stall = host_en;
    assign uc_data  = host_en ? '0 : fetch_byte;

    // R9
    fetch_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != PWR_ASLEEP) |-> (uc_stall && uc_data == '0));

    // R4
    no_early_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_WDATA && pwr_state != PWR_AWAKE) |=> $stable(wptr));

endmodule

// File: tb/iram_host_port_bench.sv
module iram_host_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] uc_addr = 8'h00;
    logic [7:0] uc_data;
    logic       uc_stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    iram_host_port u_iram_host_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .uc_addr(uc_addr), .uc_data(uc_data), .uc_stall(uc_stall)
    );

    localparam logic [1:0] OPW = 2'd1, OPR = 2'd2;
    localparam logic [2:0] A_CTL = 3'd0, A_WA = 3'd1, A_WD = 3'd2,
                           A_RA = 3'd3, A_RD = 3'd4, A_PW = 3'd5;
    localparam int NV = 67;
    // {op, offset, write data, expected read, requirement}
    localparam logic [24:0] VEC [NV] = '{
        {OPR, A_PW,  8'h00, 8'h02, 4'd1},   // R1
        {OPR, A_CTL, 8'h00, 8'h00, 4'd1},
        {OPR, A_WA,  8'h00, 8'h00, 4'd1},
        {OPR, A_RA,  8'h00, 8'h00, 4'd1},
        {OPW, A_CTL, 8'h03, 8'h00, 4'd2},   // R2 enable + write inc
        {OPR, A_PW,  8'h00, 8'h01, 4'd2},
        {OPR, A_PW,  8'h00, 8'h01, 4'd2},
        {OPR, A_PW,  8'h00, 8'h01, 4'd2},
        {OPR, A_PW,  8'h00, 8'h01, 4'd2},
        {OPR, A_PW,  8'h00, 8'h00, 4'd2},
        {OPR, A_CTL, 8'h00, 8'h03, 4'd10},  // R10
        {OPW, A_WA,  8'hF0, 8'h00, 4'd6},   // R6 stream load
        {OPW, A_WD,  8'h11, 8'h00, 4'd6},
        {OPW, A_WD,  8'h22, 8'h00, 4'd6},
        {OPW, A_WD,  8'h07, 8'h00, 4'd6},
        {OPW, A_WD,  8'hE8, 8'h00, 4'd6},
        {OPW, A_WD,  8'h03, 8'h00, 4'd6},
        {OPW, A_WD,  8'h0F, 8'h00, 4'd6},
        {OPW, A_WD,  8'h5A, 8'h00, 4'd6},
        {OPR, A_WA,  8'h00, 8'hF7, 4'd6},
        {OPW, A_CTL, 8'h05, 8'h00, 4'd7},   // R7 read inc
        {OPW, A_RA,  8'hF1, 8'h00, 4'd7},
        {OPR, A_RD,  8'h00, 8'h22, 4'd7},
        {OPR, A_RD,  8'h00, 8'h07, 4'd7},
        {OPR, A_RD,  8'h00, 8'hE8, 4'd7},
        {OPR, A_RD,  8'h00, 8'h03, 4'd7},
        {OPR, A_RD,  8'h00, 8'h0F, 4'd7},
        {OPR, A_RA,  8'h00, 8'hF6, 4'd7},
        {OPR, A_RD,  8'h00, 8'h5A, 4'd7},
        {OPW, A_RA,  8'hF0, 8'h00, 4'd7},
        {OPW, A_CTL, 8'h01, 8'h00, 4'd7},   // no increments
        {OPR, A_RD,  8'h00, 8'h11, 4'd7},
        {OPR, A_RD,  8'h00, 8'h11, 4'd7},
        {OPR, A_RA,  8'h00, 8'hF0, 4'd7},
        {OPW, A_WA,  8'h40, 8'h00, 4'd6},
        {OPW, A_WD,  8'hAA, 8'h00, 4'd6},
        {OPW, A_WD,  8'hBB, 8'h00, 4'd6},
        {OPR, A_WA,  8'h00, 8'h40, 4'd6},
        {OPW, A_RA,  8'h40, 8'h00, 4'd6},
        {OPR, A_RD,  8'h00, 8'hBB, 4'd6},
        {OPW, A_CTL, 8'h07, 8'h00, 4'd8},   // R8 wrap
        {OPW, A_WA,  8'hFF, 8'h00, 4'd8},
        {OPW, A_WD,  8'hC1, 8'h00, 4'd8},
        {OPW, A_WD,  8'hC2, 8'h00, 4'd8},
        {OPR, A_WA,  8'h00, 8'h01, 4'd8},
        {OPW, A_RA,  8'hFF, 8'h00, 4'd8},
        {OPR, A_RD,  8'h00, 8'hC1, 4'd8},
        {OPR, A_RD,  8'h00, 8'hC2, 4'd8},
        {OPR, A_RA,  8'h00, 8'h01, 4'd8},
        {OPW, A_WA,  8'h40, 8'h00, 4'd8},
        {OPW, A_CTL, 8'h00, 8'h00, 4'd3},   // R3 release
        {OPR, A_PW,  8'h00, 8'h02, 4'd3},
        {OPR, A_RD,  8'h00, 8'h00, 4'd4},   // R4 asleep
        {OPW, A_WD,  8'h99, 8'h00, 4'd4},
        {OPW, A_WA,  8'h10, 8'h00, 4'd5},   // R5
        {OPW, A_RA,  8'h20, 8'h00, 4'd5},
        {OPR, A_WA,  8'h00, 8'h40, 4'd5},
        {OPR, A_RA,  8'h00, 8'h01, 4'd5},
        {OPW, A_CTL, 8'h07, 8'h00, 4'd3},   // re-enable
        {OPW, A_WD,  8'h77, 8'h00, 4'd4},   // waking, ignored
        {OPR, A_RD,  8'h00, 8'h00, 4'd4},
        {OPR, A_WA,  8'h00, 8'h40, 4'd4},
        {OPR, A_PW,  8'h00, 8'h01, 4'd3},
        {OPR, A_PW,  8'h00, 8'h00, 4'd3},
        {OPW, A_RA,  8'h40, 8'h00, 4'd4},
        {OPR, A_RD,  8'h00, 8'hBB, 4'd4},
        {OPR, A_RA,  8'h00, 8'h41, 4'd7}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_cycle(input logic [1:0] op, input logic [2:0] ofs,
                             input logic [7:0] wd);
        @(negedge clk);
        reg_wr    = (op == OPW);
        reg_rd    = (op == OPR);
        reg_addr  = ofs;
        reg_wdata = wd;
        #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check("R1 uc_stall", 8'(uc_stall), 8'h00);

        for (int i = 0; i < NV; i++) begin
            reg_cycle(VEC[i][24:23], VEC[i][22:20], VEC[i][19:12]);
            if (VEC[i][24:23] == OPR)
                check($sformatf("R%0d vec%0d", VEC[i][3:0], i), reg_rdata, VEC[i][11:4]);
        end

        // R9: host holds memory, fetch fenced
        reg_cycle(2'd0, A_CTL, 8'h00);
        reg_wr = 1'b0; reg_rd = 1'b0;
        uc_addr = 8'hF1; #0.5;
        check("R9 stall while held", 8'(uc_stall), 8'h01);
        check("R9 data while held", uc_data, 8'h00);

        // same cycle: host store and fetch of that address
        reg_cycle(OPW, A_WA, 8'hF3);
        reg_cycle(OPW, A_WD, 8'h66);
        uc_addr = 8'hF3; #0.5;
        check("R9 collide stall", 8'(uc_stall), 8'h01);
        check("R9 collide data", uc_data, 8'h00);
        reg_cycle(OPW, A_CTL, 8'h00);
        reg_cycle(2'd0, A_CTL, 8'h00);
        check("R9 released stall", 8'(uc_stall), 8'h00);
        check("R9 fetch new byte", uc_data, 8'h66);
        uc_addr = 8'hF1; #0.5;
        check("R9 fetch version", uc_data, 8'h22);

        // R1: reset mid-run
        reg_cycle(OPW, A_CTL, 8'h07);
        reg_cycle(OPR, A_CTL, 8'h00);
        rst_n = 1'b0; #0.5;
        check("R1 ctrl after reset", reg_rdata, 8'h00);
        reg_addr = A_PW; #0.5;
        check("R1 pwr after reset", reg_rdata, 8'h02);
        reg_addr = A_WA; #0.5;
        check("R1 wptr after reset", reg_rdata, 8'h00);
        reg_addr = A_RA; #0.5;
        check("R1 rptr after reset", reg_rdata, 8'h00);
        check("R1 stall after reset", 8'(uc_stall), 8'h00);
        reg_rd = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        finish_run();
    end
endmodule